// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns bytes into an asynchronous serial character stream. A byte arrives over a valid/ready handshake and is parked in a one-entry holding register. The shift engine then takes it and sends a low start bit, the data bits least significant first, an optional parity bit and a high stop period. The number of data bits is 5 to 8, parity is even, odd or off, and the stop period lasts 1, 1.5 or 2 bit times. Every bit is timed by a 16x oversampling tick. A divider on the core clock makes that tick from a 16-bit divisor.

When hardware flow control is on, a synchronised clear-to-send input decides whether a new character may begin. It is looked at only when a character would start, so a character that is already on the line always finishes. The character format is captured when a character starts. A break control holds the line low for as long as it is set. Two status outputs report an empty holding register and a fully idle transmitter.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset `tx` is 1 and `hold_empty`, `tx_idle` and `data_ready` are all 1. While no character is in progress and `brk` is 0, `tx` stays 1.
- R2: A character is a start bit at 0, then the data bits least significant bit first, then a stop period at 1. Each bit lasts 16 ticks. With divisor 1, an 8-bit character with no parity and one stop bit takes 160 clock cycles from the start bit's falling edge until `tx_idle` returns to 1.
- R3: `word_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of the byte are sent.
- R4: `parity_mode` 2'b01 appends an even parity bit and 2'b10 appends an odd parity bit, both computed over the sent bits only. 2'b00 and 2'b11 send no parity bit.
- R5: `stop_sel` 2'b00 gives a stop period of 16 ticks, 2'b01 gives 24 ticks and 2'b10 or 2'b11 gives 32 ticks.
- R6: One tick occurs every `divisor` clock cycles. A divisor of 0 behaves like 1.
- R7: `data_ready` is 1 exactly when the holding register is empty, and a byte is accepted on a clock edge with `data_valid` and `data_ready` both 1. A byte that is waiting starts its character right after the previous stop period, with no idle gap.
- R8: With `auto_cts_en` at 1 and `cts` at 0, no character starts. A byte that is waiting stays in the holding register, so `hold_empty` and `tx_idle` stay 0 and `tx` stays 1. It starts after `cts` rises.
- R9: If `cts` falls while a character is in progress, that character still completes with its full length and data.
- R10: With `auto_cts_en` at 0, `cts` has no effect and characters start while `cts` is 0.
- R11: While `brk` is 1, `tx` is 0. When `brk` returns to 0, the line goes back to 1 if the transmitter is idle.
- R12: `tx_idle` is 1 only when no character is in progress and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| data_in | input | 8 | Byte to send |
| data_valid | input | 1 | `data_in` holds a byte to send |
| data_ready | output | 1 | Holding register can take a byte |
| word_len | input | 2 | Data bits minus 5 |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| stop_sel | input | 2 | 00 one, 01 one and a half, 1x two stop bits |
| brk | input | 1 | Force the serial line low |
| auto_cts_en | input | 1 | Enable clear-to-send gating of new characters |
| cts | input | 1 | Clear to send, active high, asynchronous |
| tx | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty |
| tx_idle | output | 1 | No character in progress and nothing waiting |

## Verification
A shift engine in the wrong state shows up within one bit time as a wrong level at a mid-bit sample point. A wrong tick count in the stop period shows up as `tx_idle` rising too early or too late, or as the next start bit moving away from the expected cycle. A faulty holding-register flag shows up at once on `data_ready` and `hold_empty`, and a byte it loses shows up as a missing character. A flow-control fault shows up either as a start bit while clear-to-send is low or as a character that is cut short when clear-to-send drops.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

   // Shift engine phases
   typedef enum logic [2:0] {
      TXS_IDLE,
      TXS_START,
      TXS_DATA,
      TXS_PARITY,
      TXS_STOP
   } txs_e;

   // Parity selection codes on the parity_mode port
   localparam logic [1:0] PAR_EVEN = 2'b01;
   localparam logic [1:0] PAR_ODD  = 2'b10;

   // Stop period codes on the stop_sel port
   localparam logic [1:0] STP_ONE  = 2'b00;
   localparam logic [1:0] STP_HALF = 2'b01;

   // Shortest character in data bits
   localparam int unsigned MIN_WORD = 5;

   // Character format captured when a character starts
   typedef struct packed {
      logic [2:0] last_bit;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop_code;
   } txfmt_t;

endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] eff;
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   always_comb begin
      eff  = (divisor == '0) ? DIV_W'(1) : divisor;
      wrap = (cnt_q >= eff - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         tick  <= wrap;
      end
   end
endmodule

// File: rtl/uatx_sync.sv
module uatx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else if (STAGES == 1) chain_q <= d;
            else chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         rd_data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_valid && !full) begin
         full    <= 1'b1;
         rd_data <= wr_data;
      end
   end
endmodule

// File: rtl/uatx_shift.sv
module uatx_shift
   import uatx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [1:0]        word_len,
   input  logic [1:0]        parity_mode,
   input  logic [1:0]        stop_sel,
   input  logic              cts_ok,
   output logic              take,
   output logic              line,
   output logic              busy
);
   localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE);
   localparam int unsigned HALF  = OVERSAMPLE / 2;
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] STOP1_LST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] STOPH_LST = CNT_W'(OVERSAMPLE + HALF - 1);
   localparam logic [CNT_W-1:0] STOP2_LST = CNT_W'(2 * OVERSAMPLE - 1);

   txs_e              state_q;
   logic [CNT_W-1:0]  sub_q;
   logic [2:0]        idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_q;
   txfmt_t            fmt_q;

   txfmt_t            fmt_in;
   logic [DATA_W-1:0] masked;
   logic              load_par;
   logic              bit_end;
   logic              stop_end;
   logic [CNT_W-1:0]  stop_last;

   // Format of the character about to start
   always_comb begin
      fmt_in.last_bit  = 3'(MIN_WORD - 1) + 3'(word_len);
      fmt_in.par_en    = (parity_mode == PAR_EVEN) || (parity_mode == PAR_ODD);
      fmt_in.par_odd   = (parity_mode == PAR_ODD);
      fmt_in.stop_code = stop_sel;
   end

   // Drop the bits above the selected length
   generate
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
         assign masked[gi] = hold_data[gi] && (gi <= int'(fmt_in.last_bit));
      end
   endgenerate

   always_comb begin
      load_par = (^masked) ^ fmt_in.par_odd;
      bit_end  = tick && (sub_q == BIT_LAST);
      case (fmt_q.stop_code)
         STP_ONE:  stop_last = STOP1_LST;
         STP_HALF: stop_last = STOPH_LST;
         default:  stop_last = STOP2_LST;
      endcase
      stop_end = (state_q == TXS_STOP) && tick && (sub_q == stop_last);
      take     = hold_full && cts_ok && ((state_q == TXS_IDLE) || stop_end);
      busy     = (state_q != TXS_IDLE);
      case (state_q)
         TXS_START:  line = 1'b0;
         TXS_DATA:   line = shreg_q[0];
         TXS_PARITY: line = par_q;
         default:    line = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         sub_q   <= '0;
         idx_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
         fmt_q   <= '0;
      end else if (take) begin
         state_q <= TXS_START;
         sub_q   <= '0;
         idx_q   <= '0;
         shreg_q <= masked;
         par_q   <= load_par;
         fmt_q   <= fmt_in;
      end else begin
         case (state_q)
            TXS_START: begin
               if (bit_end) begin
                  state_q <= TXS_DATA;
                  sub_q   <= '0;
               end else if (tick) begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            TXS_DATA: begin
               if (bit_end) begin
                  sub_q   <= '0;
                  shreg_q <= shreg_q >> 1;
                  if (idx_q == fmt_q.last_bit) begin
                     state_q <= fmt_q.par_en ? TXS_PARITY : TXS_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else if (tick) begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            TXS_PARITY: begin
               if (bit_end) begin
                  state_q <= TXS_STOP;
                  sub_q   <= '0;
               end else if (tick) begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            TXS_STOP: begin
               if (stop_end) begin
                  state_q <= TXS_IDLE;
                  sub_q   <= '0;
               end else if (tick) begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            default: begin
               sub_q <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [DATA_W-1:0] data_in,
   input  logic              data_valid,
   output logic              data_ready,
   input  logic [1:0]        word_len,
   input  logic [1:0]        parity_mode,
   input  logic [1:0]        stop_sel,
   input  logic              brk,
   input  logic              auto_cts_en,
   input  logic              cts,
   output logic              tx,
   output logic              hold_empty,
   output logic              tx_idle
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("uart_tx_cts: DATA_W must cover 8-bit characters");
      end
      if ((OVERSAMPLE < 2) || (OVERSAMPLE % 2 != 0)) begin : g_bad_os
         $error("uart_tx_cts: OVERSAMPLE must be even and at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uart_tx_cts: DIV_W must be at least 1");
      end
   endgenerate

   logic              tick;
   logic              cts_s;
   logic              cts_ok;
   logic              take;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              line;
   logic              shift_busy;

   uatx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   uatx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts),
      .q     (cts_s)
   );

   assign cts_ok = !auto_cts_en || cts_s;

   uatx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (data_in),
      .wr_valid (data_valid),
      .take     (take),
      .full     (hold_full),
      .rd_data  (hold_data)
   );

   uatx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .hold_full   (hold_full),
      .hold_data   (hold_data),
      .word_len    (word_len),
      .parity_mode (parity_mode),
      .stop_sel    (stop_sel),
      .cts_ok      (cts_ok),
      .take        (take),
      .line        (line),
      .busy        (shift_busy)
   );

   assign tx         = brk ? 1'b0 : line;
   assign data_ready = !hold_full;
   assign hold_empty = !hold_full;
   assign tx_idle    = !shift_busy && !hold_full;
endmodule

// File: rtl/uatx_chk.sv
module uatx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx,
   input logic brk,
   input logic tx_idle,
   input logic hold_empty,
   input logic data_valid,
   input logic data_ready,
   input logic busy,
   input logic cts_ok
);
   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> !tx); // R11

   AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !brk) |-> tx); // R1

   AST_IDLE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> (hold_empty && !busy)); // R12

   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && data_ready) |=> !hold_empty); // R7

   AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(hold_empty)); // R7

   AST_CTS_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cts_ok) |=> !busy); // R8
endmodule

bind uart_tx_cts uatx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx         (tx),
   .brk        (brk),
   .tx_idle    (tx_idle),
   .hold_empty (hold_empty),
   .data_valid (data_valid),
   .data_ready (data_ready),
   .busy       (shift_busy),
   .cts_ok     (cts_ok)
);

// File: tb/sim_uart_tx_cts.sv
`timescale 1ns/1ps
module sim_uart_tx_cts;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] divisor = 16'd1;
   logic [7:0]  data_in = '0;
   logic        data_valid = 1'b0;
   logic        data_ready;
   logic [1:0]  word_len = 2'd3;
   logic [1:0]  parity_mode = 2'b00;
   logic [1:0]  stop_sel = 2'b00;
   logic        brk = 1'b0;
   logic        auto_cts_en = 1'b0;
   logic        cts = 1'b1;
   logic        tx;
   logic        hold_empty;
   logic        tx_idle;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   uart_tx_cts u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .divisor     (divisor),
      .data_in     (data_in),
      .data_valid  (data_valid),
      .data_ready  (data_ready),
      .word_len    (word_len),
      .parity_mode (parity_mode),
      .stop_sel    (stop_sel),
      .brk         (brk),
      .auto_cts_en (auto_cts_en),
      .cts         (cts),
      .tx          (tx),
      .hold_empty  (hold_empty),
      .tx_idle     (tx_idle)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // Hand one byte over; all driving happens at falling edges
   task automatic send(input logic [7:0] b);
      data_in    = b;
      data_valid = 1'b1;
      while (!data_ready) @(negedge clk);
      @(negedge clk);
      data_valid = 1'b0;
   endtask

   // Receive one character, counting cycles from the first low sample
   task automatic rx_frame(input int nb, input bit pe, input int div, input bit wait_idle,
                           output logic [7:0] d, output logic p, output int dur);
      int bl    = 16 * div;
      int cur   = 0;
      int guard = 0;
      int tgt;
      d = '0; p = 1'b0; dur = 0;
      while (tx !== 1'b0 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (tx !== 1'b0) begin
         check(1'b0, "R2", "start bit seen", 0, 1);
         return;
      end
      repeat (bl / 2) @(negedge clk);
      cur = bl / 2;
      check(tx == 1'b0, "R2", "start bit level", int'(tx), 0);
      for (int k = 0; k < nb; k++) begin
         tgt = bl * (k + 1) + bl / 2;
         repeat (tgt - cur) @(negedge clk);
         cur = tgt;
         d[k] = tx;
      end
      if (pe) begin
         tgt = bl * (nb + 1) + bl / 2;
         repeat (tgt - cur) @(negedge clk);
         cur = tgt;
         p = tx;
      end
      tgt = bl * (nb + 1 + int'(pe)) + bl / 2;
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      check(tx == 1'b1, "R2", "stop level", int'(tx), 1);
      if (wait_idle) begin
         guard = 0;
         while (!tx_idle && guard < 5000) begin
            @(negedge clk);
            cur++;
            guard++;
         end
         dur = cur;
      end
   endtask

   task automatic set_fmt(input logic [1:0] wl, input logic [1:0] pm, input logic [1:0] ss);
      word_len = wl; parity_mode = pm; stop_sel = ss;
   endtask

   task automatic t_reset();
      check(tx == 1'b1, "R1", "tx after reset", int'(tx), 1);
      check(hold_empty == 1'b1, "R1", "hold_empty after reset", int'(hold_empty), 1);
      check(tx_idle == 1'b1, "R1", "tx_idle after reset", int'(tx_idle), 1);
      check(data_ready == 1'b1, "R1", "data_ready after reset", int'(data_ready), 1);
      repeat (20) @(negedge clk);
      check(tx == 1'b1, "R1", "line quiet while idle", int'(tx), 1);
   endtask

   task automatic t_basic();
      logic [7:0] d; logic p; int dur;
      set_fmt(2'd3, 2'b00, 2'b00);
      send(8'hA5);
      check(tx_idle == 1'b0, "R12", "tx_idle with byte pending", int'(tx_idle), 0);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'hA5, "R2", "8N1 data", int'(d), 'hA5);
      check(dur == 160, "R2", "8N1 length", dur, 160);
      check(tx_idle == 1'b1, "R12", "tx_idle after frame", int'(tx_idle), 1);
   endtask

   task automatic t_wordlen();
      logic [7:0] d; logic p; int dur;
      set_fmt(2'd0, 2'b00, 2'b00);
      send(8'hE6);
      rx_frame(5, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'h06, "R3", "5-bit data", int'(d), 'h06);
      check(dur == 112, "R3", "5-bit length", dur, 112);
      set_fmt(2'd2, 2'b00, 2'b00);
      send(8'hDB);
      rx_frame(7, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'h5B, "R3", "7-bit data", int'(d), 'h5B);
      check(dur == 144, "R3", "7-bit length", dur, 144);
   endtask

   task automatic t_parity();
      logic [7:0] d; logic p; int dur;
      set_fmt(2'd3, 2'b01, 2'b00);
      send(8'h37);
      rx_frame(8, 1'b1, 1, 1'b1, d, p, dur);
      check(d == 8'h37, "R4", "even data", int'(d), 'h37);
      check(p == 1'b1, "R4", "even parity bit", int'(p), 1);
      check(dur == 176, "R4", "parity frame length", dur, 176);
      set_fmt(2'd3, 2'b10, 2'b00);
      send(8'h37);
      rx_frame(8, 1'b1, 1, 1'b1, d, p, dur);
      check(p == 1'b0, "R4", "odd parity bit", int'(p), 0);
      set_fmt(2'd2, 2'b01, 2'b00);
      send(8'hFF);
      rx_frame(7, 1'b1, 1, 1'b1, d, p, dur);
      check(p == 1'b1, "R4", "even parity on 7 sent bits", int'(p), 1);
      set_fmt(2'd3, 2'b11, 2'b00);
      send(8'h01);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(dur == 160, "R4", "code 11 sends no parity", dur, 160);
   endtask

   task automatic t_stop();
      logic [7:0] d; logic p; int dur;
      set_fmt(2'd3, 2'b00, 2'b01);
      send(8'h3C);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(dur == 168, "R5", "1.5 stop length", dur, 168);
      set_fmt(2'd3, 2'b00, 2'b10);
      send(8'h3C);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(dur == 176, "R5", "2 stop length", dur, 176);
      set_fmt(2'd3, 2'b00, 2'b11);
      send(8'h3C);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(dur == 176, "R5", "code 11 stop length", dur, 176);
   endtask

   task automatic t_divisor();
      logic [7:0] d; logic p; int dur;
      set_fmt(2'd3, 2'b00, 2'b00);
      divisor = 16'd3;
      send(8'h96);
      rx_frame(8, 1'b0, 3, 1'b1, d, p, dur);
      check(d == 8'h96, "R6", "divisor 3 data", int'(d), 'h96);
      check(dur >= 478 && dur <= 480, "R6", "divisor 3 length", dur, 480);
      divisor = 16'd0;
      send(8'h69);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'h69, "R6", "divisor 0 data", int'(d), 'h69);
      check(dur == 160, "R6", "divisor 0 length", dur, 160);
      divisor = 16'd1;
   endtask

   task automatic t_backtoback();
      logic [7:0] d1; logic [7:0] d2; logic p; int dur;
      set_fmt(2'd3, 2'b00, 2'b00);
      send(8'h81);
      check(data_ready == 1'b0, "R7", "ready low while holding", int'(data_ready), 0);
      fork
         send(8'h7E);
         rx_frame(8, 1'b0, 1, 1'b0, d1, p, dur);
      join
      check(d1 == 8'h81, "R7", "first byte", int'(d1), 'h81);
      repeat (7) @(negedge clk);
      check(tx == 1'b1, "R7", "last stop cycle", int'(tx), 1);
      @(negedge clk);
      check(tx == 1'b0, "R7", "next start without gap", int'(tx), 0);
      rx_frame(8, 1'b0, 1, 1'b1, d2, p, dur);
      check(d2 == 8'h7E, "R7", "second byte", int'(d2), 'h7E);
      check(dur == 160, "R7", "second frame length", dur, 160);
   endtask

   task automatic t_cts_block();
      logic [7:0] d; logic p; int dur; int lows = 0;
      set_fmt(2'd3, 2'b00, 2'b00);
      auto_cts_en = 1'b1;
      cts = 1'b0;
      repeat (4) @(negedge clk);
      send(8'h5A);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tx == 1'b0) lows++;
      end
      check(lows == 0, "R8", "no start while cts low", lows, 0);
      check(hold_empty == 1'b0, "R8", "byte kept in holding register", int'(hold_empty), 0);
      check(tx_idle == 1'b0, "R8", "not idle while blocked", int'(tx_idle), 0);
      cts = 1'b1;
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'h5A, "R8", "data after cts rises", int'(d), 'h5A);
   endtask

   task automatic t_cts_midframe();
      logic [7:0] d; logic p; int dur;
      auto_cts_en = 1'b1;
      cts = 1'b1;
      repeat (4) @(negedge clk);
      send(8'hC3);
      fork
         rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
         begin
            repeat (40) @(negedge clk);
            cts = 1'b0;
         end
      join
      check(d == 8'hC3, "R9", "frame completes after cts drop", int'(d), 'hC3);
      check(dur == 160, "R9", "full length after cts drop", dur, 160);
      cts = 1'b1;
   endtask

   task automatic t_cts_ignored();
      logic [7:0] d; logic p; int dur;
      auto_cts_en = 1'b0;
      cts = 1'b0;
      repeat (4) @(negedge clk);
      send(8'h2D);
      rx_frame(8, 1'b0, 1, 1'b1, d, p, dur);
      check(d == 8'h2D, "R10", "sent with cts low and gating off", int'(d), 'h2D);
      cts = 1'b1;
   endtask

   task automatic t_break();
      brk = 1'b1;
      #1;
      check(tx == 1'b0, "R11", "break drives low", int'(tx), 0);
      repeat (30) @(negedge clk);
      check(tx == 1'b0, "R11", "break held low", int'(tx), 0);
      brk = 1'b0;
      #1;
      check(tx == 1'b1, "R11", "line released after break", int'(tx), 1);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wordlen();
      t_parity();
      t_stop();
      t_divisor();
      t_backtoback();
      t_cts_block();
      t_cts_midframe();
      t_cts_ignored();
      t_break();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule